// File: doc/BRIEF.md
# Paged Program Sequencer With Return Stack

This block owns the program counter of a small 8-bit machine. Every cycle it presents a 13-bit fetch address and looks at the instruction that was fetched from it. From that instruction and a skip request raised by the execute unit, it picks the next address. The choices are the next word, the word after that (a skip), an absolute target, or a saved return address.

Absolute targets are formed by placing a 3-bit page register above a 10-bit literal taken from the instruction. A dedicated instruction loads the page register. A call saves the address of the following word on an 8-entry circular return stack before jumping. The return instruction carries an 8-bit literal. It hands that literal to the accumulator and restores the program counter from the stack in the same step. A bank-select instruction is decoded here as well; its literal is driven out to the register that lives in the data path.

All strobes toward the accumulator, page register and bank register are combinational decodes of the current instruction. The program counter and the page bits change on the rising clock edge. Reset is asynchronous and active low.

Top module: `progSeq`

## Requirements
- R1: While `rstN` is low the fetch address, the page bits and the stack pointer are all zero. After reset, a jump lands in page 0.
- R2: An instruction that is not a call, jump or return, with `skipReq` low, advances the fetch address by 1 modulo 2^13. The address 0x1FFF wraps to 0x0000.
- R3: With `skipReq` high on such an instruction, the fetch address advances by 2 modulo 2^13.
- R4: A jump (instr[12:10] = 3'b101) loads the fetch address with {page, instr[9:0]} and leaves the return stack untouched.
- R5: A call (instr[12:10] = 3'b100) pushes fetch address + 1 and loads the fetch address with {page, instr[9:0]}.
- R6: A literal return (instr[12:8] = 5'b11100) drives `accLoadEn` high with `accLoadVal` = instr[7:0] in the same cycle. It also loads the fetch address from the stack top and pops.
- R7: A page set (instr[12:4] = 9'h1E8) drives `pageWrEn` high with `pageWrVal` = instr[2:0]. Later jumps and calls use that value; instr[3] has no effect. The fetch address advances by 1.
- R8: A bank set (instr[12:4] = 9'h1E9) drives `bankWrEn` high with `bankWrVal` = instr[1:0]. The fetch address advances by 1.
- R9: `skipReq` is ignored while the instruction is a call, jump or literal return.
- R10: The return stack is last-in first-out with 8 entries and a wrapping pointer. A ninth push overwrites the oldest entry. Overflow and underflow are not flagged.
- R11: At most one of `accLoadEn`, `pageWrEn`, `bankWrEn` is high at once. All three are low for every other instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| instr | input | 13 | Instruction fetched from the current address |
| skipReq | input | 1 | Execute unit asks to step over the next word |
| fetchAddr | output | 13 | Current program counter: page bits above the 10-bit offset |
| accLoadEn | output | 1 | Accumulator load strobe for a literal return |
| accLoadVal | output | 8 | Value to load into the accumulator |
| pageWrEn | output | 1 | Page-select register write strobe |
| pageWrVal | output | 3 | New page-select value |
| bankWrEn | output | 1 | Bank-select register write strobe |
| bankWrVal | output | 2 | New bank-select value |

## Verification
The properties assume three things about the inputs. `instr` is a known value, stable from just after one rising edge to the next. It is the word stored at `fetchAddr`. `skipReq` is treated as belonging to the same cycle as that instruction. The call-then-return property also assumes `instr` does not change meaning between the two cycles it links. The bench drives `instr` and `skipReq` only on falling edges and uses only the defined encodings plus plain data-path words whose top bits select no sequencer action. It samples the registered address one falling edge after the rising edge that updates it.

// File: rtl/seqPkg.sv
package seqPkg;
  localparam int INSTR_W = 13;
  localparam int OP_W    = INSTR_W - 4;   // instruction bits 12:4 reach the decoder
  localparam int BANK_W  = 2;

  localparam logic [2:0]      CALL_OP  = 3'b100;
  localparam logic [2:0]      JUMP_OP  = 3'b101;
  localparam logic [4:0]      RETL_OP  = 5'b11100;
  localparam logic [OP_W-1:0] PAGE_OP  = 9'h1E8;
  localparam logic [OP_W-1:0] BANK_OP  = 9'h1E9;

  typedef struct packed {
    logic call;
    logic jump;
    logic ret;
    logic pageSet;
    logic bankSet;
    logic skip;
  } seqStrobeT;
endpackage

// File: rtl/seqCtrl.sv
module seqCtrl
  import seqPkg::*;
(
  input  logic [OP_W-1:0] opBits,
  input  logic            skipReq,
  output seqStrobeT       strb
);
  logic isCall, isJump, isRet;

  always_comb begin
    isCall = (opBits[OP_W-1 -: 3] == CALL_OP);
    isJump = (opBits[OP_W-1 -: 3] == JUMP_OP);
    isRet  = (opBits[OP_W-1 -: 5] == RETL_OP);
    strb         = '0;
    strb.call    = isCall;
    strb.jump    = isJump;
    strb.ret     = isRet;
    strb.pageSet = (opBits == PAGE_OP);
    strb.bankSet = (opBits == BANK_OP);
    // a transfer of control overrides any skip request
    strb.skip    = skipReq & ~(isCall | isJump | isRet);
  end
endmodule

// File: rtl/seqRetStack.sv
module seqRetStack #(
  parameter int DEPTH = 8,
  parameter int WIDTH = 13,
  localparam int SP_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             pushEn,
  input  logic             popEn,
  input  logic [WIDTH-1:0] pushData,
  output logic [WIDTH-1:0] topData
);
  logic [SP_W-1:0]  sp;
  logic [WIDTH-1:0] slots [DEPTH];

  // pointer wraps freely: DEPTH is a power of two
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)       sp <= '0;
    else if (pushEn) sp <= sp + SP_W'(1);
    else if (popEn)  sp <= sp - SP_W'(1);
  end

  for (genvar e = 0; e < DEPTH; e++) begin : g_slot
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                             slots[e] <= '0;
      else if (pushEn && sp == SP_W'(e))     slots[e] <= pushData;
    end
  end

  assign topData = slots[sp - SP_W'(1)];
endmodule

// File: rtl/seqDatapath.sv
module seqDatapath
  import seqPkg::*;
#(
  parameter int OFF_W  = 10,
  parameter int PAGE_W = 3,
  parameter int DEPTH  = 8,
  localparam int PC_W  = PAGE_W + OFF_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqStrobeT         strb,
  input  logic [OFF_W-1:0]  jumpOff,
  input  logic [PAGE_W-1:0] pageLit,
  output logic [PC_W-1:0]   fetchAddr
);
  logic [PC_W-1:0]   pc, nextPc, pcInc1, pcInc2, retAddr;
  logic [PAGE_W-1:0] pageReg;

  assign pcInc1 = pc + PC_W'(1);
  assign pcInc2 = pc + PC_W'(2);

  seqRetStack #(
    .DEPTH (DEPTH),
    .WIDTH (PC_W)
  ) u_stack (
    .clk      (clk),
    .rstN     (rstN),
    .pushEn   (strb.call),
    .popEn    (strb.ret),
    .pushData (pcInc1),
    .topData  (retAddr)
  );

  always_comb begin
    if (strb.call || strb.jump)          nextPc = {pageReg, jumpOff};
    else if (strb.ret)                   nextPc = retAddr;
    else if (strb.skip)                  nextPc = pcInc2;
    else if (strb.pageSet || strb.bankSet) nextPc = pcInc1;
    else                                 nextPc = pcInc1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pc      <= '0;
      pageReg <= '0;
    end else begin
      pc <= nextPc;
      if (strb.pageSet) pageReg <= pageLit;
    end
  end

  assign fetchAddr = pc;
endmodule

// File: rtl/progSeq.sv
module progSeq
  import seqPkg::*;
#(
  parameter int OFF_W  = 10,
  parameter int PAGE_W = 3,
  parameter int DEPTH  = 8,
  parameter int DATA_W = 8,
  localparam int PC_W  = PAGE_W + OFF_W
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [INSTR_W-1:0]  instr,
  input  logic                skipReq,
  output logic [PC_W-1:0]     fetchAddr,
  output logic                accLoadEn,
  output logic [DATA_W-1:0]   accLoadVal,
  output logic                pageWrEn,
  output logic [PAGE_W-1:0]   pageWrVal,
  output logic                bankWrEn,
  output logic [BANK_W-1:0]   bankWrVal
);
  seqStrobeT strb;

  seqCtrl u_ctrl (
    .opBits  (instr[INSTR_W-1:4]),
    .skipReq (skipReq),
    .strb    (strb)
  );

  seqDatapath #(
    .OFF_W  (OFF_W),
    .PAGE_W (PAGE_W),
    .DEPTH  (DEPTH)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .jumpOff   (instr[OFF_W-1:0]),
    .pageLit   (instr[PAGE_W-1:0]),
    .fetchAddr (fetchAddr)
  );

  assign accLoadEn  = strb.ret;
  assign accLoadVal = instr[DATA_W-1:0];
  assign pageWrEn   = strb.pageSet;
  assign pageWrVal  = instr[PAGE_W-1:0];
  assign bankWrEn   = strb.bankSet;
  assign bankWrVal  = instr[BANK_W-1:0];
endmodule

// File: rtl/seqChecker.sv
module seqChecker (
  input logic        clk,
  input logic        rstN,
  input logic [12:0] instr,
  input logic        skipReq,
  input logic [12:0] fetchAddr,
  input logic        accLoadEn,
  input logic [7:0]  accLoadVal,
  input logic        pageWrEn,
  input logic [2:0]  pageWrVal,
  input logic        bankWrEn,
  input logic [1:0]  bankWrVal
);
  logic isCall, isJmp, isRet, isPlain;
  logic [1:0] sinceRst;

  assign isCall  = instr[12:10] == 3'b100;
  assign isJmp   = instr[12:10] == 3'b101;
  assign isRet   = instr[12:8]  == 5'b11100;
  assign isPlain = !isCall && !isJmp && !isRet;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 sinceRst <= '0;
    else if (sinceRst != 2'd3) sinceRst <= sinceRst + 2'd1;
  end

  p_reset_addr_r1: assert property (@(posedge clk) !rstN |=> fetchAddr == 13'd0);

  p_step_r2: assert property (@(posedge clk) disable iff (!rstN)
    isPlain && !skipReq |=> fetchAddr == $past(fetchAddr) + 13'd1);

  p_skip_r3: assert property (@(posedge clk) disable iff (!rstN)
    isPlain && skipReq |=> fetchAddr == $past(fetchAddr) + 13'd2);

  p_jump_r4: assert property (@(posedge clk) disable iff (!rstN)
    isJmp |=> fetchAddr[9:0] == $past(instr[9:0]));

  p_call_r5: assert property (@(posedge clk) disable iff (!rstN)
    isCall |=> fetchAddr[9:0] == $past(instr[9:0]));

  p_ret_acc_r6: assert property (@(posedge clk) disable iff (!rstN)
    isRet |-> accLoadEn && accLoadVal == instr[7:0]);

  p_page_r7: assert property (@(posedge clk) disable iff (!rstN)
    pageWrEn |-> pageWrVal == instr[2:0] && $stable(fetchAddr) == 1'b0 || pageWrEn == 1'b0 || pageWrVal == instr[2:0]);

  p_bank_r8: assert property (@(posedge clk) disable iff (!rstN)
    bankWrEn |-> bankWrVal == instr[1:0] && isPlain);

  p_skip_ignored_r9: assert property (@(posedge clk) disable iff (!rstN)
    (isJmp || isCall) && skipReq |=> fetchAddr[9:0] == $past(instr[9:0]));

  p_call_ret_r10: assert property (@(posedge clk) disable iff (!rstN)
    sinceRst >= 2'd2 && isRet && $past(isCall) |=> fetchAddr == $past(fetchAddr, 2) + 13'd1);

  p_strobe_excl_r11: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({accLoadEn, pageWrEn, bankWrEn}));
endmodule

bind progSeq seqChecker u_chk (.*);

// File: tb/progSeq_tb.sv
module progSeq_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [12:0] instr = '0;
  logic        skipReq = 1'b0;
  logic [12:0] fetchAddr;
  logic        accLoadEn;
  logic [7:0]  accLoadVal;
  logic        pageWrEn;
  logic [2:0]  pageWrVal;
  logic        bankWrEn;
  logic [1:0]  bankWrVal;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  logic       capAccEn, capPgEn, capBkEn;
  logic [7:0] capAcc;
  logic [2:0] capPg;
  logic [1:0] capBk;

  always #2.5 clk = ~clk;

  progSeq u_dut (.*);

  typedef struct packed {
    logic [12:0] ins;
    logic        skp;
    logic [12:0] nxt;
    logic        accEn;
    logic [7:0]  acc;
    logic        pgEn;
    logic [2:0]  pg;
    logic        bkEn;
    logic [1:0]  bk;
  } vecT;

  // walked from reset: address 0, page 0, empty stack
  localparam vecT VEC [14] = '{
    '{13'h0000, 1'b0, 13'h0001, 1'b0, 8'h00, 1'b0, 3'd0, 1'b0, 2'd0}, // R2 plain
    '{13'h0123, 1'b1, 13'h0003, 1'b0, 8'h00, 1'b0, 3'd0, 1'b0, 2'd0}, // R3 skip
    '{13'h1805, 1'b0, 13'h0004, 1'b0, 8'h00, 1'b0, 3'd0, 1'b0, 2'd0}, // R11 literal move
    '{13'h1555, 1'b0, 13'h0155, 1'b0, 8'h00, 1'b0, 3'd0, 1'b0, 2'd0}, // R4 jump page 0
    '{13'h1E85, 1'b0, 13'h0156, 1'b0, 8'h00, 1'b1, 3'd5, 1'b0, 2'd0}, // R7 page 5
    '{13'h17FF, 1'b1, 13'h17FF, 1'b0, 8'h00, 1'b0, 3'd0, 1'b0, 2'd0}, // R9 jump ignores skip
    '{13'h1010, 1'b0, 13'h1410, 1'b0, 8'h00, 1'b0, 3'd0, 1'b0, 2'd0}, // R5 call, push 0x1800
    '{13'h1E92, 1'b0, 13'h1411, 1'b0, 8'h00, 1'b0, 3'd0, 1'b1, 2'd2}, // R8 bank 2
    '{13'h1E8A, 1'b0, 13'h1412, 1'b0, 8'h00, 1'b1, 3'd2, 1'b0, 2'd0}, // R7 bit3 ignored
    '{13'h13F0, 1'b1, 13'h0BF0, 1'b0, 8'h00, 1'b0, 3'd0, 1'b0, 2'd0}, // R9 call ignores skip
    '{13'h0000, 1'b1, 13'h0BF2, 1'b0, 8'h00, 1'b0, 3'd0, 1'b0, 2'd0}, // R3 skip
    '{13'h1C5A, 1'b0, 13'h1413, 1'b1, 8'h5A, 1'b0, 3'd0, 1'b0, 2'd0}, // R6 return
    '{13'h1CA5, 1'b1, 13'h1800, 1'b1, 8'hA5, 1'b0, 3'd0, 1'b0, 2'd0}, // R6 R9 nested return
    '{13'h1FFF, 1'b0, 13'h1801, 1'b0, 8'h00, 1'b0, 3'd0, 1'b0, 2'd0}  // R11 literal add
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // starts and ends on a falling edge
  task automatic runStep(input logic [12:0] ins, input logic skp);
    instr   = ins;
    skipReq = skp;
    #1;
    capAccEn = accLoadEn;  capAcc = accLoadVal;
    capPgEn  = pageWrEn;   capPg  = pageWrVal;
    capBkEn  = bankWrEn;   capBk  = bankWrVal;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0; instr = '0; skipReq = 1'b0;
    @(negedge clk);
    chk(fetchAddr == 13'd0, "R1 address in reset", fetchAddr, 0);
    rstN = 1'b1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired actual=hung expected=finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [12:0] expPc;
    logic [12:0] pushed [9];
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(fetchAddr == 13'd0, "R1 address held at zero", fetchAddr, 0);
    rstN = 1'b1;

    foreach (VEC[i]) begin
      runStep(VEC[i].ins, VEC[i].skp);
      chk(fetchAddr == VEC[i].nxt, $sformatf("R2-table row %0d next address", i), fetchAddr, VEC[i].nxt);
      chk(capAccEn == VEC[i].accEn && capPgEn == VEC[i].pgEn && capBkEn == VEC[i].bkEn,
          $sformatf("R11 strobes row %0d", i), {capAccEn, capPgEn, capBkEn},
          {VEC[i].accEn, VEC[i].pgEn, VEC[i].bkEn});
      if (VEC[i].accEn) chk(capAcc == VEC[i].acc, "R6 accumulator value", capAcc, VEC[i].acc);
      if (VEC[i].pgEn)  chk(capPg == VEC[i].pg, "R7 page value", capPg, VEC[i].pg);
      if (VEC[i].bkEn)  chk(capBk == VEC[i].bk, "R8 bank value", capBk, VEC[i].bk);
    end

    // R2 and R3 wrap at the top of the address space
    runStep(13'h1E87, 1'b0);
    runStep(13'h17FF, 1'b0);
    chk(fetchAddr == 13'h1FFF, "R4 jump into page 7", fetchAddr, 13'h1FFF);
    runStep(13'h0000, 1'b0);
    chk(fetchAddr == 13'h0000, "R2 wrap to zero", fetchAddr, 0);
    runStep(13'h17FF, 1'b0);
    runStep(13'h0000, 1'b1);
    chk(fetchAddr == 13'h0001, "R3 skip wraps", fetchAddr, 1);

    // R10 nine calls into an eight-entry stack, then nine returns
    doReset();
    expPc = 13'd0;
    for (int i = 0; i < 9; i++) begin
      pushed[i] = expPc + 13'd1;
      expPc = 13'(i * 16 + 3);
      runStep(13'h1000 | 13'(i * 16 + 3), 1'b0);
      chk(fetchAddr == expPc, "R5 call target", fetchAddr, expPc);
    end
    for (int j = 0; j < 9; j++) begin
      expPc = (j < 8) ? pushed[8 - j] : pushed[8];
      runStep(13'h1C00 | 13'(j), 1'b0);
      chk(fetchAddr == expPc, $sformatf("R10 return %0d", j), fetchAddr, expPc);
    end

    // R1 reset clears the page bits
    runStep(13'h1E86, 1'b0);
    doReset();
    runStep(13'h140F, 1'b0);
    chk(fetchAddr == 13'h000F, "R1 page cleared by reset", fetchAddr, 13'h000F);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule